// File: doc/BRIEF.md
# DMA Channel Loop-Control Engine

This block is a single transfer engine shared by several DMA channels. Each channel owns a descriptor held in a small register store: source address, destination address, a per-service byte count, a starting iteration count and a live iteration count, plus a control/status word. A channel asks for service either through software, by setting its start bit, or through a hardware request line gated by a per-channel enable. A round-robin arbiter picks one requesting channel. The engine copies that channel's whole descriptor into working registers, checks it, and then runs one minor loop: a sequence of word reads from the source followed by word writes to the destination until the byte count has moved.

After every minor loop the advanced addresses and the decremented iteration count are written back to the store and the engine returns to arbitration, so channels interleave at minor-loop granularity. When the live count reaches zero the major loop is complete: the done flag is set, the count is reloaded from the starting value, the hardware enable may be dropped, and an interrupt flag may be raised. A separate flag marks the half-way point. The scatter/gather bit is stored and readable only; it starts no action.

The bus side is two valid/ready request channels (read address, write address plus data) and one valid/ready read-data return. An asserted `rd_valid` or `wr_valid` holds its address and data unchanged until the matching ready is seen high at a clock edge; the engine keeps `rd_dat_ready` high for as long as it waits for a read word, and only one of `rd_valid`, `rd_dat_ready` and `wr_valid` is ever high at a time. The configuration port and interrupt pins are plain signals.

Top module: `dma_loop_engine`

## Requirements
- R1: After reset the engine is idle (`busy`, `rd_valid`, `wr_valid` low), all interrupt pins are low and every descriptor field of every channel reads 0.
- R2: A configuration write with `cfg_we` high stores `cfg_wdata` into the field chosen by `cfg_field` (0 source, 1 destination, 2 byte count, 3 iteration count, which loads both the starting and live counts, 5 control/status); field 4 reads the live count. `cfg_rdata` combinationally returns the addressed field. A write to a channel whose ACTIVE bit is set is dropped.
- R3: One service of a valid descriptor issues NBYTES/4 reads at source+4k, each followed by one write of the read word to destination+4k, k counting up from 0.
- R4: Once `rd_valid` or `wr_valid` is raised it stays high with stable address (and write data) until the matching ready is sampled high.
- R5: At the end of each minor loop the stored source and destination addresses equal their old values plus NBYTES, and the live count is one lower.
- R6: When the decremented live count is zero, DONE (control/status bit 2) is set and the live count is reloaded from the starting count.
- R7: START (bit 0) requests a software service and is cleared when the engine loads the descriptor; ACTIVE (bit 1) reads 1 from the load until the write-back of that service and 0 otherwise.
- R8: A descriptor with byte count 0, a byte count not a multiple of 4, or a starting or live count of 0 makes no bus access, clears START, sets the error bit (bit 8) and leaves the addresses and counts unchanged; any control/status write clears the error bit.
- R9: If D_REQ (bit 3) is set, major-loop completion clears the hardware-request enable (bit 7); with D_REQ clear the enable stays set.
- R10: With INT_HALF enable (bit 5) set, `irq_half[ch]` (mirrored in bit 9) rises when the decremented live count equals the starting count divided by 2 (rounded down); with INT_MAJ enable (bit 6), `irq_major[ch]` (bit 10) rises at completion. Both stay high until a control/status write with a 1 in bit 9 or bit 10 respectively; other bits written are 5, 6, 7, 4, 3, 2, 0.
- R11: Arbitration is round-robin over requesting channels and happens after every minor loop, so two channels requesting continuously alternate service.
- R12: A hardware request line is ignored while the channel's enable (bit 7) is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | NCH | Hardware service request per channel (level) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Channel addressed by the configuration port |
| cfg_field | input | 3 | Descriptor field select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Addressed field, zero-extended |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read word address |
| rd_dat_valid | input | 1 | Read data valid |
| rd_dat_ready | output | 1 | Engine waiting for read data |
| rd_dat | input | DW | Read data word |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | AW | Write word address |
| wr_data | output | DW | Write data word |
| irq_half | output | NCH | Half-way interrupt flag per channel |
| irq_major | output | NCH | Major-loop completion interrupt flag per channel |
| busy | output | 1 | Engine is loading, transferring or writing back |

## Verification
The half-way flag and the completion flag can be set in the same write-back: when the starting count is 1, the decremented count 0 equals both the half point (1/2 rounded down) and the exhausted state. The bench programs a channel with both interrupt enables and a count of 1, launches it, and watches both pins on every cycle of the service, judging a failure if one rises in a cycle where the other does not, and confirming both are high afterwards. Ordinary counts are used around it to show the two flags rising in separate services.

// File: rtl/dma_loop_pkg.sv
package dma_loop_pkg;

  typedef enum logic [2:0] {
    FLD_SRC  = 3'd0,
    FLD_DST  = 3'd1,
    FLD_LEN  = 3'd2,
    FLD_ITER = 3'd3,
    FLD_CUR  = 3'd4,
    FLD_CSR  = 3'd5
  } fld_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RREQ,
    ST_RDAT,
    ST_WREQ,
    ST_WB
  } eng_st_e;

  // control/status bit positions
  localparam int B_START  = 0;
  localparam int B_ACTIVE = 1;
  localparam int B_DONE   = 2;
  localparam int B_DREQ   = 3;
  localparam int B_SGEN   = 4;
  localparam int B_HIE    = 5;
  localparam int B_MIE    = 6;
  localparam int B_HWEN   = 7;
  localparam int B_ERR    = 8;
  localparam int B_HPEND  = 9;
  localparam int B_MPEND  = 10;
  localparam int CSR_W    = 11;

endpackage

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
  parameter int N   = 4,
  parameter int CHW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req,
  input  logic           take,
  output logic           any,
  output logic [CHW-1:0] gnt
);

  logic [CHW-1:0] last_q;

  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(last_q) + k) % N;
      if (!found && req[c]) begin
        found = 1'b1;
        gnt   = CHW'(c);
      end
    end
    any = found;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= CHW'(N - 1);
    else if (take) last_q <= gnt;
  end

endmodule

// File: rtl/dma_desc_store.sv
module dma_desc_store
  import dma_loop_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CHW = 2,
  parameter int AW  = 32,
  parameter int IW  = 16,
  parameter int LW  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CHW-1:0]   cfg_ch,
  input  logic [2:0]       cfg_field,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [NCH-1:0]   hw_req,
  output logic [NCH-1:0]   pend,
  input  logic [CHW-1:0]   sel_ch,
  output logic [AW-1:0]    d_saddr,
  output logic [AW-1:0]    d_daddr,
  output logic [LW-1:0]    d_nbytes,
  output logic [IW-1:0]    d_biter,
  output logic [IW-1:0]    d_citer,
  output logic             d_hie,
  output logic             d_mie,
  output logic             d_dreq,
  input  logic             launch,
  input  logic             err_set,
  input  logic             wb_en,
  input  logic [AW-1:0]    wb_saddr,
  input  logic [AW-1:0]    wb_daddr,
  input  logic [IW-1:0]    wb_citer,
  input  logic             wb_done,
  input  logic             wb_hwen_clr,
  input  logic             wb_half,
  input  logic             wb_maj,
  output logic [NCH-1:0]   irq_half,
  output logic [NCH-1:0]   irq_major
);

  logic [NCH-1:0][AW-1:0]    sa_all, da_all;
  logic [NCH-1:0][LW-1:0]    nb_all;
  logic [NCH-1:0][IW-1:0]    bi_all, ci_all;
  logic [NCH-1:0][CSR_W-1:0] csr_all;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [AW-1:0] sa, da;
    logic [LW-1:0] nb;
    logic [IW-1:0] bi, ci;
    logic start, active, done, dreq, sgen, hie, mie, hwen, err, hpend, mpend;
    logic cfg_hit, eng_hit;

    assign cfg_hit = cfg_we && (cfg_ch == CHW'(i)) && !active;
    assign eng_hit = (sel_ch == CHW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sa <= '0; da <= '0; nb <= '0; bi <= '0; ci <= '0;
        start <= 1'b0; active <= 1'b0; done <= 1'b0; dreq <= 1'b0;
        sgen <= 1'b0; hie <= 1'b0; mie <= 1'b0; hwen <= 1'b0;
        err <= 1'b0; hpend <= 1'b0; mpend <= 1'b0;
      end else begin
        if (cfg_hit) begin
          case (fld_e'(cfg_field))
            FLD_SRC:  sa <= cfg_wdata[AW-1:0];
            FLD_DST:  da <= cfg_wdata[AW-1:0];
            FLD_LEN:  nb <= cfg_wdata[LW-1:0];
            FLD_ITER: begin
              bi <= cfg_wdata[IW-1:0];
              ci <= cfg_wdata[IW-1:0];
            end
            FLD_CSR: begin
              start <= cfg_wdata[B_START];
              done  <= cfg_wdata[B_DONE];
              dreq  <= cfg_wdata[B_DREQ];
              sgen  <= cfg_wdata[B_SGEN];
              hie   <= cfg_wdata[B_HIE];
              mie   <= cfg_wdata[B_MIE];
              hwen  <= cfg_wdata[B_HWEN];
              err   <= 1'b0;
              if (cfg_wdata[B_HPEND]) hpend <= 1'b0;
              if (cfg_wdata[B_MPEND]) mpend <= 1'b0;
            end
            default: ;
          endcase
        end
        if (eng_hit && launch) begin
          start  <= 1'b0;
          active <= 1'b1;
        end
        if (eng_hit && err_set) begin
          active <= 1'b0;
          err    <= 1'b1;
        end
        if (eng_hit && wb_en) begin
          sa     <= wb_saddr;
          da     <= wb_daddr;
          ci     <= wb_citer;
          active <= 1'b0;
          if (wb_done)     done  <= 1'b1;
          if (wb_hwen_clr) hwen  <= 1'b0;
          if (wb_half)     hpend <= 1'b1;
          if (wb_maj)      mpend <= 1'b1;
        end
      end
    end

    assign sa_all[i]  = sa;
    assign da_all[i]  = da;
    assign nb_all[i]  = nb;
    assign bi_all[i]  = bi;
    assign ci_all[i]  = ci;
    assign csr_all[i] = {mpend, hpend, err, hwen, mie, hie, sgen, dreq, done, active, start};
    assign pend[i]      = start || (hw_req[i] && hwen);
    assign irq_half[i]  = hpend;
    assign irq_major[i] = mpend;
  end

  assign d_saddr  = sa_all[sel_ch];
  assign d_daddr  = da_all[sel_ch];
  assign d_nbytes = nb_all[sel_ch];
  assign d_biter  = bi_all[sel_ch];
  assign d_citer  = ci_all[sel_ch];
  assign d_hie    = csr_all[sel_ch][B_HIE];
  assign d_mie    = csr_all[sel_ch][B_MIE];
  assign d_dreq   = csr_all[sel_ch][B_DREQ];

  always_comb begin
    cfg_rdata = '0;
    case (fld_e'(cfg_field))
      FLD_SRC:  cfg_rdata[AW-1:0]    = sa_all[cfg_ch];
      FLD_DST:  cfg_rdata[AW-1:0]    = da_all[cfg_ch];
      FLD_LEN:  cfg_rdata[LW-1:0]    = nb_all[cfg_ch];
      FLD_ITER: cfg_rdata[IW-1:0]    = bi_all[cfg_ch];
      FLD_CUR:  cfg_rdata[IW-1:0]    = ci_all[cfg_ch];
      FLD_CSR:  cfg_rdata[CSR_W-1:0] = csr_all[cfg_ch];
      default:  cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_loop_pkg::*;
#(
  parameter int CHW = 2,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int IW  = 16,
  parameter int LW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           any_req,
  input  logic [CHW-1:0] gnt_ch,
  output logic           arb_take,
  output logic [CHW-1:0] cur_ch,
  input  logic [AW-1:0]  d_saddr,
  input  logic [AW-1:0]  d_daddr,
  input  logic [LW-1:0]  d_nbytes,
  input  logic [IW-1:0]  d_biter,
  input  logic [IW-1:0]  d_citer,
  input  logic           d_hie,
  input  logic           d_mie,
  input  logic           d_dreq,
  output logic           launch,
  output logic           err_set,
  output logic           wb_en,
  output logic [AW-1:0]  wb_saddr,
  output logic [AW-1:0]  wb_daddr,
  output logic [IW-1:0]  wb_citer,
  output logic           wb_done,
  output logic           wb_hwen_clr,
  output logic           wb_half,
  output logic           wb_maj,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [AW-1:0]  rd_addr,
  input  logic           rd_dat_valid,
  output logic           rd_dat_ready,
  input  logic [DW-1:0]  rd_dat,
  output logic           wr_valid,
  input  logic           wr_ready,
  output logic [AW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic           busy
);

  localparam int BPB = DW / 8;
  localparam int BSH = $clog2(BPB);

  eng_st_e        st_q;
  logic [CHW-1:0] ch_q;
  logic [AW-1:0]  sa_q, da_q;
  logic [LW-1:0]  left_q;
  logic [IW-1:0]  bi_q, ci_q;
  logic           hie_q, mie_q, dreq_q;
  logic [DW-1:0]  dat_q;
  logic           bad_desc;
  logic [IW-1:0]  ci_dec;
  logic           exhausted;

  assign bad_desc = (d_nbytes == '0) || (d_nbytes[BSH-1:0] != '0) ||
                    (d_biter == '0) || (d_citer == '0);
  assign ci_dec    = ci_q - IW'(1);
  assign exhausted = (ci_dec == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ch_q <= '0;
      sa_q <= '0; da_q <= '0; left_q <= '0;
      bi_q <= '0; ci_q <= '0;
      hie_q <= 1'b0; mie_q <= 1'b0; dreq_q <= 1'b0;
      dat_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (any_req) begin
          ch_q <= gnt_ch;
          st_q <= ST_LOAD;
        end
        ST_LOAD: begin
          sa_q   <= d_saddr;
          da_q   <= d_daddr;
          left_q <= d_nbytes;
          bi_q   <= d_biter;
          ci_q   <= d_citer;
          hie_q  <= d_hie;
          mie_q  <= d_mie;
          dreq_q <= d_dreq;
          st_q   <= bad_desc ? ST_IDLE : ST_RREQ;
        end
        ST_RREQ: if (rd_ready) st_q <= ST_RDAT;
        ST_RDAT: if (rd_dat_valid) begin
          dat_q <= rd_dat;
          st_q  <= ST_WREQ;
        end
        ST_WREQ: if (wr_ready) begin
          sa_q   <= sa_q + AW'(BPB);
          da_q   <= da_q + AW'(BPB);
          left_q <= left_q - LW'(BPB);
          st_q   <= (left_q == LW'(BPB)) ? ST_WB : ST_RREQ;
        end
        ST_WB:   st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign arb_take     = (st_q == ST_IDLE) && any_req;
  assign cur_ch       = ch_q;
  assign launch       = (st_q == ST_LOAD);
  assign err_set      = (st_q == ST_LOAD) && bad_desc;
  assign rd_valid     = (st_q == ST_RREQ);
  assign rd_addr      = sa_q;
  assign rd_dat_ready = (st_q == ST_RDAT);
  assign wr_valid     = (st_q == ST_WREQ);
  assign wr_addr      = da_q;
  assign wr_data      = dat_q;
  assign busy         = (st_q != ST_IDLE);

  assign wb_en       = (st_q == ST_WB);
  assign wb_saddr    = sa_q;
  assign wb_daddr    = da_q;
  assign wb_citer    = exhausted ? bi_q : ci_dec;
  assign wb_done     = exhausted;
  assign wb_hwen_clr = exhausted && dreq_q;
  assign wb_maj      = exhausted && mie_q;
  assign wb_half     = hie_q && (ci_dec == (bi_q >> 1));

endmodule

// File: rtl/dma_loop_engine.sv
module dma_loop_engine #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int IW  = 16,
  parameter int LW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hw_req,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [2:0]     cfg_field,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [AW-1:0]  rd_addr,
  input  logic           rd_dat_valid,
  output logic           rd_dat_ready,
  input  logic [DW-1:0]  rd_dat,
  output logic           wr_valid,
  input  logic           wr_ready,
  output logic [AW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic [NCH-1:0] irq_half,
  output logic [NCH-1:0] irq_major,
  output logic           busy
);

  logic [NCH-1:0] pend;
  logic           any_req, arb_take;
  logic [CHW-1:0] gnt_ch, cur_ch;
  logic [AW-1:0]  d_saddr, d_daddr, wb_saddr, wb_daddr;
  logic [LW-1:0]  d_nbytes;
  logic [IW-1:0]  d_biter, d_citer, wb_citer;
  logic           d_hie, d_mie, d_dreq;
  logic           launch, err_set, wb_en, wb_done, wb_hwen_clr, wb_half, wb_maj;

  dma_rr_arb #(.N(NCH), .CHW(CHW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(pend), .take(arb_take),
    .any(any_req), .gnt(gnt_ch)
  );

  dma_desc_store #(.NCH(NCH), .CHW(CHW), .AW(AW), .IW(IW), .LW(LW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_field(cfg_field),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .hw_req(hw_req), .pend(pend), .sel_ch(cur_ch),
    .d_saddr(d_saddr), .d_daddr(d_daddr), .d_nbytes(d_nbytes),
    .d_biter(d_biter), .d_citer(d_citer),
    .d_hie(d_hie), .d_mie(d_mie), .d_dreq(d_dreq),
    .launch(launch), .err_set(err_set), .wb_en(wb_en),
    .wb_saddr(wb_saddr), .wb_daddr(wb_daddr), .wb_citer(wb_citer),
    .wb_done(wb_done), .wb_hwen_clr(wb_hwen_clr),
    .wb_half(wb_half), .wb_maj(wb_maj),
    .irq_half(irq_half), .irq_major(irq_major)
  );

  dma_xfer_fsm #(.CHW(CHW), .AW(AW), .DW(DW), .IW(IW), .LW(LW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .any_req(any_req), .gnt_ch(gnt_ch), .arb_take(arb_take), .cur_ch(cur_ch),
    .d_saddr(d_saddr), .d_daddr(d_daddr), .d_nbytes(d_nbytes),
    .d_biter(d_biter), .d_citer(d_citer),
    .d_hie(d_hie), .d_mie(d_mie), .d_dreq(d_dreq),
    .launch(launch), .err_set(err_set), .wb_en(wb_en),
    .wb_saddr(wb_saddr), .wb_daddr(wb_daddr), .wb_citer(wb_citer),
    .wb_done(wb_done), .wb_hwen_clr(wb_hwen_clr),
    .wb_half(wb_half), .wb_maj(wb_maj),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_dat_valid(rd_dat_valid), .rd_dat_ready(rd_dat_ready), .rd_dat(rd_dat),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy)
  );

endmodule

// File: rtl/dma_loop_chk.sv
module dma_loop_chk #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           rd_valid,
  input logic           rd_ready,
  input logic [AW-1:0]  rd_addr,
  input logic           rd_dat_ready,
  input logic           wr_valid,
  input logic           wr_ready,
  input logic [AW-1:0]  wr_addr,
  input logic [DW-1:0]  wr_data,
  input logic [NCH-1:0] irq_half,
  input logic [NCH-1:0] irq_major
);

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R4

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_valid && !wr_valid && !rd_dat_ready); // R3

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rd_valid, rd_dat_ready, wr_valid}) <= 1); // R3

  for (genvar i = 0; i < NCH; i++) begin : g_irq
    AST_MAJ_FROM_SVC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_major[i]) |-> $past(busy)); // R10
    AST_HALF_FROM_SVC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_half[i]) |-> $past(busy)); // R10
  end

endmodule

bind dma_loop_engine dma_loop_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .rd_dat_ready(rd_dat_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .irq_half(irq_half), .irq_major(irq_major)
);

// File: tb/sim_dma_loop_engine.sv
module sim_dma_loop_engine;

  localparam int F_SRC = 0, F_DST = 1, F_LEN = 2, F_ITER = 3, F_CUR = 4, F_CSR = 5;
  localparam logic [31:0] C_START = 32'h1, C_ACT = 32'h2, C_DONE = 32'h4, C_DREQ = 32'h8;
  localparam logic [31:0] C_HIE = 32'h20, C_MIE = 32'h40, C_HWEN = 32'h80, C_ERR = 32'h100;
  localparam logic [31:0] C_HP = 32'h200, C_MP = 32'h400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  hw_req = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [2:0]  cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        rd_valid, rd_ready, rd_dat_valid, rd_dat_ready;
  logic [31:0] rd_addr, rd_dat, wr_addr, wr_data;
  logic        wr_valid, wr_ready;
  logic [3:0]  irq_half, irq_major;
  logic        busy;
  logic        stall = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign rd_ready = !stall;
  assign wr_ready = !stall;

  dma_loop_engine u0 (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_field(cfg_field),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_dat_valid(rd_dat_valid), .rd_dat_ready(rd_dat_ready), .rd_dat(rd_dat),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_half(irq_half), .irq_major(irq_major), .busy(busy)
  );

  function automatic logic [31:0] src_word(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  // memory model and write log
  logic [31:0] wa [64];
  logic [31:0] wd [64];
  int wcnt = 0;
  int rcnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_dat_valid <= 1'b0;
      rd_dat <= '0;
    end else if (rd_valid && rd_ready) begin
      rd_dat_valid <= 1'b1;
      rd_dat <= src_word(rd_addr);
      rcnt <= rcnt + 1;
    end else if (rd_dat_valid && rd_dat_ready) begin
      rd_dat_valid <= 1'b0;
    end
    if (rst_n && wr_valid && wr_ready) begin
      if (wcnt < 64) begin
        wa[wcnt] <= wr_addr;
        wd[wcnt] <= wr_data;
      end
      wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input int ch, input int f, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_field = 3'(f); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input int ch, input int f, output logic [31:0] v);
    @(negedge clk);
    cfg_ch = 2'(ch); cfg_field = 3'(f);
    #1 v = cfg_rdata;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
  endtask

  task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                       input logic [31:0] nb, input logic [31:0] it);
    cfg_wr(ch, F_SRC, s);
    cfg_wr(ch, F_DST, d);
    cfg_wr(ch, F_LEN, nb);
    cfg_wr(ch, F_ITER, it);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 bus valid", {30'b0, rd_valid, wr_valid}, 0);
    chk("R1 irq", {24'b0, irq_half, irq_major}, 0);
    for (int c = 0; c < 4; c++) begin
      for (int f = 0; f < 6; f++) begin
        cfg_rd(c, f, v);
        chk("R1 field", v, 0);
      end
    end
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    setup(1, 32'hAAAA_0000, 32'hBBBB_0000, 32'h10, 32'h7);
    cfg_rd(1, F_SRC, v);  chk("R2 src", v, 32'hAAAA_0000);
    cfg_rd(1, F_DST, v);  chk("R2 dst", v, 32'hBBBB_0000);
    cfg_rd(1, F_LEN, v);  chk("R2 len", v, 32'h10);
    cfg_rd(1, F_ITER, v); chk("R2 iter", v, 7);
    cfg_rd(1, F_CUR, v);  chk("R2 cur", v, 7);
  endtask

  task automatic t_minor();
    logic [31:0] v;
    int w0;
    setup(0, 32'h1000, 32'h2000, 12, 3);
    w0 = wcnt;
    cfg_wr(0, F_CSR, C_START);
    wait_idle();
    chk("R3 beats", 32'(wcnt - w0), 3);
    for (int k = 0; k < 3; k++) begin
      chk("R3 waddr", wa[w0 + k], 32'h2000 + 32'(4 * k));
      chk("R3 wdata", wd[w0 + k], src_word(32'h1000 + 32'(4 * k)));
    end
    cfg_rd(0, F_SRC, v); chk("R5 src wb", v, 32'h100C);
    cfg_rd(0, F_DST, v); chk("R5 dst wb", v, 32'h200C);
    cfg_rd(0, F_CUR, v); chk("R5 citer wb", v, 2);
    cfg_rd(0, F_CSR, v); chk("R7 start/active clear", v & (C_START | C_ACT | C_DONE), 0);
    cfg_wr(0, F_CSR, C_START);
    wait_idle();
    cfg_wr(0, F_CSR, C_START);
    wait_idle();
    cfg_rd(0, F_CUR, v); chk("R6 citer reload", v, 3);
    cfg_rd(0, F_CSR, v); chk("R6 done", v & C_DONE, C_DONE);
    cfg_rd(0, F_SRC, v); chk("R5 src after 3", v, 32'h1024);
  endtask

  task automatic t_stall();
    logic [31:0] v;
    int w0;
    setup(2, 32'h5000, 32'h6000, 8, 2);
    w0 = wcnt;
    stall = 1'b1;
    cfg_wr(2, F_CSR, C_START);
    repeat (4) @(negedge clk);
    chk("R4 rd_valid up", 32'(rd_valid), 1);
    chk("R4 rd_addr", rd_addr, 32'h5000);
    repeat (3) @(negedge clk);
    chk("R4 rd_valid held", 32'(rd_valid), 1);
    chk("R4 rd_addr held", rd_addr, 32'h5000);
    cfg_rd(2, F_CSR, v);
    chk("R7 active in service", v & (C_START | C_ACT), C_ACT);
    cfg_wr(2, F_SRC, 32'hDEAD_0000);
    @(negedge clk);
    stall = 1'b0;
    wait_idle();
    chk("R3 stall beats", 32'(wcnt - w0), 2);
    chk("R3 stall data", wd[w0 + 1], src_word(32'h5004));
    cfg_rd(2, F_SRC, v); chk("R2 write dropped while active", v, 32'h5008);
  endtask

  task automatic t_err();
    logic [31:0] v;
    int r0;
    setup(3, 32'h7000, 32'h8000, 6, 2);
    r0 = rcnt;
    cfg_wr(3, F_CSR, C_START);
    wait_idle();
    chk("R8 no bus access", 32'(rcnt - r0), 0);
    cfg_rd(3, F_CSR, v); chk("R8 err set start clear", v & (C_ERR | C_START | C_ACT), C_ERR);
    cfg_rd(3, F_SRC, v); chk("R8 src unchanged", v, 32'h7000);
    cfg_rd(3, F_CUR, v); chk("R8 citer unchanged", v, 2);
    cfg_wr(3, F_LEN, 4);
    cfg_wr(3, F_ITER, 0);
    cfg_wr(3, F_CSR, C_START);
    wait_idle();
    chk("R8 zero count no access", 32'(rcnt - r0), 0);
    cfg_rd(3, F_CSR, v); chk("R8 zero count err", v & C_ERR, C_ERR);
    cfg_wr(3, F_CSR, 0);
    cfg_rd(3, F_CSR, v); chk("R8 err cleared", v & C_ERR, 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    bit mism;
    setup(1, 32'h9000, 32'hA000, 4, 4);
    for (int r = 0; r < 2; r++) begin
      cfg_wr(1, F_CSR, C_HIE | C_MIE | C_START);
      wait_idle();
      if (r == 0) chk("R10 no half at 3", 32'(irq_half[1]), 0);
    end
    chk("R10 half at 2", 32'(irq_half[1]), 1);
    chk("R10 no major at 2", 32'(irq_major[1]), 0);
    cfg_rd(1, F_CSR, v); chk("R10 half mirror", v & C_HP, C_HP);
    cfg_wr(1, F_CSR, C_HIE | C_MIE | C_HP);
    chk("R10 half w1c", 32'(irq_half[1]), 0);
    for (int r = 0; r < 2; r++) begin
      cfg_wr(1, F_CSR, C_HIE | C_MIE | C_START);
      wait_idle();
    end
    chk("R10 major at end", 32'(irq_major[1]), 1);
    chk("R10 half quiet at end", 32'(irq_half[1]), 0);
    cfg_wr(1, F_ITER, 1);
    cfg_wr(1, F_CSR, C_HIE | C_MIE | C_HP | C_MP | C_START);
    mism = 0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (irq_half[1] !== irq_major[1]) mism = 1;
    end
    chk("R10 same-cycle half/major", 32'(mism), 0);
    chk("R10 both raised", {30'b0, irq_half[1], irq_major[1]}, 32'h3);
    cfg_wr(1, F_CSR, C_HP | C_MP);
  endtask

  task automatic t_hwreq();
    logic [31:0] v;
    int w0;
    setup(2, 32'hC000, 32'hD000, 4, 2);
    cfg_wr(2, F_CSR, C_DREQ);
    w0 = wcnt;
    @(negedge clk); hw_req[2] = 1'b1;
    repeat (15) @(negedge clk);
    chk("R12 disabled line ignored", 32'(wcnt - w0), 0);
    chk("R12 idle", 32'(busy), 0);
    cfg_wr(2, F_CSR, C_DREQ | C_HWEN);
    repeat (40) @(negedge clk);
    chk("R9 two loops then stop", 32'(wcnt - w0), 2);
    cfg_rd(2, F_CSR, v); chk("R9 enable cleared", v & (C_HWEN | C_DONE), C_DONE);
    cfg_wr(2, F_CSR, C_HWEN);
    repeat (40) @(negedge clk);
    cfg_rd(2, F_CSR, v); chk("R9 enable kept", v & C_HWEN, C_HWEN);
    @(negedge clk); hw_req[2] = 1'b0;
    wait_idle();
    cfg_wr(2, F_CSR, 0);
  endtask

  task automatic t_rr();
    int w0;
    bit alt;
    setup(0, 32'h1_0000, 32'h3000, 4, 8);
    setup(1, 32'h2_0000, 32'h4000, 4, 8);
    cfg_wr(0, F_CSR, C_HWEN);
    cfg_wr(1, F_CSR, C_HWEN);
    w0 = wcnt;
    @(negedge clk); hw_req[1:0] = 2'b11;
    for (int n = 0; n < 200 && (wcnt - w0) < 6; n++) @(negedge clk);
    hw_req[1:0] = 2'b00;
    wait_idle();
    alt = 1;
    for (int k = 0; k < 4; k++) begin
      if (wa[w0 + k][15:12] == wa[w0 + k + 1][15:12]) alt = 0;
    end
    chk("R11 alternation", 32'(alt), 1);
    chk("R11 ch0 stepped", 32'(wa[w0][15:12] == 4'h3 ? wa[w0 + 2] : wa[w0 + 3]), 32'h3004);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL WDOG act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_minor();
    t_stall();
    t_err();
    t_irq();
    t_hwreq();
    t_rr();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule